// File: doc/BRIEF.md
# Non-stalling Hazard Forwarding Unit

This block sits beside a hash-table pipeline whose table updates take several cycles to land. Every cycle the execute stage reports the key it just handled together with its forwarding record: the slot valid vector, the index of the matching slot, a match flag and a 2-bit operation code. At the same rate the examine stage presents a lookup key. After a fixed latency the unit returns, for that lookup, the record of the newest execute-stage operation on the same key. When there is no such operation it reports a miss. The pipeline never has to stall, because the data that a pending update would have changed is handed forward instead.

The history of executed operations is a delay line of depth D = RD_LAT + WR_LAT. A lookup walks through D registered compare stages. At each stage it meets one history entry, the operation currently at the execute port, and the result carried from the stage before. Keeping the newest match is therefore settled one stage at a time, so the logic depth per cycle does not grow with D. The lookup leaves D cycles after it entered. By then it has been compared against every push from D cycles before its arrival up to the cycle before its departure.

Top module: `fwd_unit`

## Requirements
- R1: While rst_ni is low, and after it is released, res_valid_o and res_hit_o are low and all record outputs are zero; no push presented before the release can produce a hit afterwards.
- R2: A lookup presented with look_valid_i high in cycle t appears in cycle t+D with res_valid_o high and res_key_o equal to its key; a new lookup is accepted in every cycle without any stall.
- R3: A valid lookup in cycle t hits (res_hit_o high) exactly when some cycle c with t-D <= c <= t+D-1 had exe_valid_i high and exe_key_i equal to the lookup key.
- R4: When several pushes in that window match, the outputs res_vvec_o, res_slot_o, res_match_o and res_op_o carry the fields of the push in the latest such cycle, bit for bit.
- R5: A cycle with exe_valid_i low never causes a hit, whatever exe_key_i and the record inputs hold.
- R6: On a valid lookup that misses, res_hit_o is low and res_vvec_o, res_slot_o, res_match_o and res_op_o are all zero.
- R7: A cycle with look_valid_i low gives res_valid_o and res_hit_o low D cycles later, whatever look_key_i holds.
- R8: A matching push in cycle t-D-1 or in cycle t+D, just outside the window, does not make the lookup of cycle t hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exe_valid_i | input | 1 | An execute-stage operation is presented this cycle |
| exe_key_i | input | KEY_W | Key of the executed operation |
| exe_vvec_i | input | SLOTS | Slot valid vector after the operation |
| exe_slot_i | input | SLOT_W | Index of the matching slot |
| exe_match_i | input | 1 | A matching slot exists |
| exe_op_i | input | 2 | Operation code |
| look_valid_i | input | 1 | A lookup key is presented this cycle |
| look_key_i | input | KEY_W | Lookup key from the examine stage |
| res_valid_o | output | 1 | Result for the lookup of D cycles ago |
| res_key_o | output | KEY_W | Key of that lookup |
| res_hit_o | output | 1 | A matching push was found |
| res_vvec_o | output | SLOTS | Forwarded slot valid vector |
| res_slot_o | output | SLOT_W | Forwarded matching slot index |
| res_match_o | output | 1 | Forwarded match flag |
| res_op_o | output | 2 | Forwarded operation code |

## Verification
The bench builds the unit with RD_LAT=2 and WR_LAT=3, so D=5, with an 8-bit key and four slots. An odd, non-square depth means both window edges, t-D and t+D-1, fall on cycles the scenarios can reach with a single push. The short key lets a stream built from four key values collide often. Matches in history entries, matches against the live execute record, and ties between the two all occur within a few hundred cycles.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int unsigned OP_W = 2;

  // origin of the result carried between compare stages
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_HIST = 2'd1,
    SRC_LIVE = 2'd2
  } fwd_src_e;
endpackage

// File: rtl/fwd_history.sv
module fwd_history #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned KEY_W = 16,
  parameter int unsigned REC_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_valid_i,
  input  logic [KEY_W-1:0] push_key_i,
  input  logic [REC_W-1:0] push_rec_i,
  output logic             old_valid_o,
  output logic [KEY_W-1:0] old_key_o,
  output logic [REC_W-1:0] old_rec_o
);
  logic [DEPTH-1:0] v_q;
  logic [KEY_W-1:0] k_q [DEPTH];
  logic [REC_W-1:0] r_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        k_q[i] <= '0;
        r_q[i] <= '0;
      end
    end else begin
      v_q[0] <= push_valid_i;
      k_q[0] <= push_key_i;
      r_q[0] <= push_rec_i;
      for (int i = 1; i < DEPTH; i++) begin
        v_q[i] <= v_q[i-1];
        k_q[i] <= k_q[i-1];
        r_q[i] <= r_q[i-1];
      end
    end
  end

  // lookup and history advance in lockstep, so every stage needs the oldest entry
  assign old_valid_o = v_q[DEPTH-1];
  assign old_key_o   = k_q[DEPTH-1];
  assign old_rec_o   = r_q[DEPTH-1];
endmodule

// File: rtl/fwd_stage.sv
module fwd_stage import fwd_pkg::*; #(
  parameter int unsigned KEY_W = 16,
  parameter int unsigned REC_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [KEY_W-1:0] in_key_i,
  input  logic [REC_W-1:0] in_rec_i,
  input  fwd_src_e         in_src_i,
  input  logic             live_valid_i,
  input  logic [KEY_W-1:0] live_key_i,
  input  logic [REC_W-1:0] live_rec_i,
  input  logic             hist_valid_i,
  input  logic [KEY_W-1:0] hist_key_i,
  input  logic [REC_W-1:0] hist_rec_i,
  output logic             out_valid_o,
  output logic [KEY_W-1:0] out_key_o,
  output logic [REC_W-1:0] out_rec_o,
  output fwd_src_e         out_src_o
);
  logic             live_hit, hist_hit;
  logic [REC_W-1:0] nxt_rec;
  fwd_src_e         nxt_src;

  assign live_hit = in_valid_i && live_valid_i && (live_key_i == in_key_i);
  assign hist_hit = in_valid_i && hist_valid_i && (hist_key_i == in_key_i);

  always_comb begin
    nxt_rec = in_rec_i;
    nxt_src = in_src_i;
    if (live_hit) begin
      nxt_rec = live_rec_i;
      nxt_src = SRC_LIVE;
    end else if (hist_hit && in_src_i != SRC_LIVE) begin
      // history entry is newer than anything carried from history
      nxt_rec = hist_rec_i;
      nxt_src = SRC_HIST;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_key_o   <= '0;
      out_rec_o   <= '0;
      out_src_o   <= SRC_NONE;
    end else begin
      out_valid_o <= in_valid_i;
      out_key_o   <= in_key_i;
      out_rec_o   <= nxt_rec;
      out_src_o   <= nxt_src;
    end
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit import fwd_pkg::*; #(
  parameter int unsigned KEY_W  = 16,
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned RD_LAT = 2,
  parameter int unsigned WR_LAT = 2,
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exe_valid_i,
  input  logic [KEY_W-1:0]  exe_key_i,
  input  logic [SLOTS-1:0]  exe_vvec_i,
  input  logic [SLOT_W-1:0] exe_slot_i,
  input  logic              exe_match_i,
  input  logic [OP_W-1:0]   exe_op_i,
  input  logic              look_valid_i,
  input  logic [KEY_W-1:0]  look_key_i,
  output logic              res_valid_o,
  output logic [KEY_W-1:0]  res_key_o,
  output logic              res_hit_o,
  output logic [SLOTS-1:0]  res_vvec_o,
  output logic [SLOT_W-1:0] res_slot_o,
  output logic              res_match_o,
  output logic [OP_W-1:0]   res_op_o
);
  localparam int unsigned DEPTH = RD_LAT + WR_LAT;
  localparam int unsigned REC_W = SLOTS + SLOT_W + 1 + OP_W;

  logic [REC_W-1:0] exe_rec;
  logic             old_valid;
  logic [KEY_W-1:0] old_key;
  logic [REC_W-1:0] old_rec;

  logic             st_valid [DEPTH+1];
  logic [KEY_W-1:0] st_key   [DEPTH+1];
  logic [REC_W-1:0] st_rec   [DEPTH+1];
  fwd_src_e         st_src   [DEPTH+1];

  assign exe_rec = {exe_vvec_i, exe_slot_i, exe_match_i, exe_op_i};

  fwd_history #(.DEPTH(DEPTH), .KEY_W(KEY_W), .REC_W(REC_W)) i_history (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_valid_i(exe_valid_i),
    .push_key_i  (exe_key_i),
    .push_rec_i  (exe_rec),
    .old_valid_o (old_valid),
    .old_key_o   (old_key),
    .old_rec_o   (old_rec)
  );

  assign st_valid[0] = look_valid_i;
  assign st_key[0]   = look_key_i;
  assign st_rec[0]   = '0;
  assign st_src[0]   = SRC_NONE;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    fwd_stage #(.KEY_W(KEY_W), .REC_W(REC_W)) i_stage (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .in_valid_i  (st_valid[g]),
      .in_key_i    (st_key[g]),
      .in_rec_i    (st_rec[g]),
      .in_src_i    (st_src[g]),
      .live_valid_i(exe_valid_i),
      .live_key_i  (exe_key_i),
      .live_rec_i  (exe_rec),
      .hist_valid_i(old_valid),
      .hist_key_i  (old_key),
      .hist_rec_i  (old_rec),
      .out_valid_o (st_valid[g+1]),
      .out_key_o   (st_key[g+1]),
      .out_rec_o   (st_rec[g+1]),
      .out_src_o   (st_src[g+1])
    );
  end

  assign res_valid_o = st_valid[DEPTH];
  assign res_key_o   = st_key[DEPTH];
  assign res_hit_o   = st_src[DEPTH] != SRC_NONE;
  assign {res_vvec_o, res_slot_o, res_match_o, res_op_o} = st_rec[DEPTH];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk import fwd_pkg::*; #(
  parameter int unsigned KEY_W  = 16,
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned RD_LAT = 2,
  parameter int unsigned WR_LAT = 2,
  parameter int unsigned SLOT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exe_valid_i,
  input logic [KEY_W-1:0]  exe_key_i,
  input logic [SLOTS-1:0]  exe_vvec_i,
  input logic [SLOT_W-1:0] exe_slot_i,
  input logic              exe_match_i,
  input logic [OP_W-1:0]   exe_op_i,
  input logic              look_valid_i,
  input logic [KEY_W-1:0]  look_key_i,
  input logic              res_valid_o,
  input logic [KEY_W-1:0]  res_key_o,
  input logic              res_hit_o,
  input logic [SLOTS-1:0]  res_vvec_o,
  input logic [SLOT_W-1:0] res_slot_o,
  input logic              res_match_o,
  input logic [OP_W-1:0]   res_op_o
);
  localparam int unsigned DEPTH = RD_LAT + WR_LAT;

  logic [DEPTH-1:0] sh_v;
  logic [KEY_W-1:0] sh_k [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_v <= '0;
      for (int i = 0; i < DEPTH; i++) sh_k[i] <= '0;
    end else begin
      sh_v[0] <= look_valid_i;
      sh_k[0] <= look_key_i;
      for (int i = 1; i < DEPTH; i++) begin
        sh_v[i] <= sh_v[i-1];
        sh_k[i] <= sh_k[i-1];
      end
    end
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o == sh_v[DEPTH-1]);

  p_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> res_key_o == sh_k[DEPTH-1]);

  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> !res_hit_o);

  p_miss_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_hit_o) |->
      ({res_vvec_o, res_slot_o, res_match_o, res_op_o} == '0));

  p_live_newest_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && $past(exe_valid_i) && ($past(exe_key_i) == res_key_o)) |->
      (res_hit_o && res_vvec_o == $past(exe_vvec_i) && res_slot_o == $past(exe_slot_i)
       && res_match_o == $past(exe_match_i) && res_op_o == $past(exe_op_i)));
endmodule

bind fwd_unit fwd_unit_chk #(
  .KEY_W (KEY_W),
  .SLOTS (SLOTS),
  .RD_LAT(RD_LAT),
  .WR_LAT(WR_LAT),
  .SLOT_W(SLOT_W)
) i_fwd_unit_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .exe_valid_i (exe_valid_i),
  .exe_key_i   (exe_key_i),
  .exe_vvec_i  (exe_vvec_i),
  .exe_slot_i  (exe_slot_i),
  .exe_match_i (exe_match_i),
  .exe_op_i    (exe_op_i),
  .look_valid_i(look_valid_i),
  .look_key_i  (look_key_i),
  .res_valid_o (res_valid_o),
  .res_key_o   (res_key_o),
  .res_hit_o   (res_hit_o),
  .res_vvec_o  (res_vvec_o),
  .res_slot_o  (res_slot_o),
  .res_match_o (res_match_o),
  .res_op_o    (res_op_o)
);

// File: tb/test_fwd_unit.sv
`timescale 1ns/1ps
module test_fwd_unit;
  import fwd_pkg::*;

  localparam int unsigned KEY_W  = 8;
  localparam int unsigned SLOTS  = 4;
  localparam int unsigned RD_LAT = 2;
  localparam int unsigned WR_LAT = 3;
  localparam int          D      = RD_LAT + WR_LAT;
  localparam int unsigned SLOT_W = 2;
  localparam int unsigned REC_W  = SLOTS + SLOT_W + 1 + OP_W;
  localparam int          LOG_N  = 4096;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              exe_valid_i = 1'b0;
  logic [KEY_W-1:0]  exe_key_i = '0;
  logic [SLOTS-1:0]  exe_vvec_i = '0;
  logic [SLOT_W-1:0] exe_slot_i = '0;
  logic              exe_match_i = 1'b0;
  logic [OP_W-1:0]   exe_op_i = '0;
  logic              look_valid_i = 1'b0;
  logic [KEY_W-1:0]  look_key_i = '0;
  logic              res_valid_o;
  logic [KEY_W-1:0]  res_key_o;
  logic              res_hit_o;
  logic [SLOTS-1:0]  res_vvec_o;
  logic [SLOT_W-1:0] res_slot_o;
  logic              res_match_o;
  logic [OP_W-1:0]   res_op_o;

  fwd_unit #(.KEY_W(KEY_W), .SLOTS(SLOTS), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT)) i_fwd_unit (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .exe_valid_i(exe_valid_i), .exe_key_i(exe_key_i), .exe_vvec_i(exe_vvec_i),
    .exe_slot_i(exe_slot_i), .exe_match_i(exe_match_i), .exe_op_i(exe_op_i),
    .look_valid_i(look_valid_i), .look_key_i(look_key_i),
    .res_valid_o(res_valid_o), .res_key_o(res_key_o), .res_hit_o(res_hit_o),
    .res_vvec_o(res_vvec_o), .res_slot_o(res_slot_o), .res_match_o(res_match_o),
    .res_op_o(res_op_o)
  );

  always #2 clk_i = ~clk_i;

  int cyc = 0;
  int base = 0;
  int checks = 0;
  int errors = 0;
  string req = "R1";

  always @(posedge clk_i) cyc <= cyc + 1;

  logic             lv_log [LOG_N];
  logic [KEY_W-1:0] lk_log [LOG_N];
  logic             ev_log [LOG_N];
  logic [KEY_W-1:0] ek_log [LOG_N];
  logic [REC_W-1:0] er_log [LOG_N];

  function automatic logic [REC_W:0] expect_rec(input int t);
    for (int c = t + D - 1; c >= t - D; c--) begin
      if (c >= base && c >= 0 && ev_log[c] && ek_log[c] == lk_log[t])
        return {1'b1, er_log[c]};
    end
    return '0;
  endfunction

  task automatic check_out();
    int t;
    logic [REC_W:0] act, exp;
    t   = cyc - D;
    act = {res_hit_o, res_vvec_o, res_slot_o, res_match_o, res_op_o};
    checks++;
    if (t >= base && t >= 0 && lv_log[t]) begin
      exp = expect_rec(t);
      if (!res_valid_o || res_key_o != lk_log[t] || act != exp) begin
        errors++;
        $display("FAIL %s R2 lookup t=%0d: valid=%0b key=%h rec=%h, expected valid=1 key=%h rec=%h",
                 req, t, res_valid_o, res_key_o, act, lk_log[t], exp);
      end
    end else if (res_valid_o || res_hit_o) begin
      errors++;
      $display("FAIL R7 (%s) idle slot t=%0d: valid=%0b hit=%0b, expected 0 0",
               req, t, res_valid_o, res_hit_o);
    end
  endtask

  task automatic step(input logic ev, input logic [KEY_W-1:0] ek, input logic [REC_W-1:0] er,
                      input logic lv, input logic [KEY_W-1:0] lk);
    @(negedge clk_i);
    check_out();
    exe_valid_i = ev;
    exe_key_i   = ek;
    {exe_vvec_i, exe_slot_i, exe_match_i, exe_op_i} = er;
    look_valid_i = lv;
    look_key_i   = lk;
    ev_log[cyc] = ev; ek_log[cyc] = ek; er_log[cyc] = er;
    lv_log[cyc] = lv; lk_log[cyc] = lk;
  endtask

  task automatic flush();
    for (int i = 0; i < 2 * D + 1; i++) step(1'b0, '0, '0, 1'b0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    exe_valid_i = 1'b0; look_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    checks++;
    if (res_valid_o || res_hit_o || {res_vvec_o, res_slot_o, res_match_o, res_op_o} != '0) begin
      errors++;
      $display("FAIL R1 in reset: valid=%0b hit=%0b rec=%h, expected all zero",
               res_valid_o, res_hit_o, {res_vvec_o, res_slot_o, res_match_o, res_op_o});
    end
    rst_ni = 1'b1;
    base = cyc;
    ev_log[cyc] = 1'b0; lv_log[cyc] = 1'b0;
    ek_log[cyc] = '0; lk_log[cyc] = '0; er_log[cyc] = '0;
  endtask

  // R8 boundaries: one push at i=D, lookups every cycle from 0 to 2D+1
  task automatic t_window();
    req = "R3 R8";
    for (int i = 0; i < 2 * D + 2; i++)
      step(i == D, 8'h11, REC_W'(9'h15A), 1'b1, 8'h11);
    flush();
  endtask

  task automatic t_newest();
    req = "R4";
    for (int i = 0; i < 2 * D; i++)
      step(i == 0 || i == 2 || i == 4 || i == 3, (i == 3) ? 8'h23 : 8'h22,
           REC_W'(i * 61 + 7), 1'b1, 8'h22);
    flush();
  endtask

  task automatic t_no_push();
    req = "R5";
    for (int i = 0; i < 2 * D; i++)
      step(1'b0, 8'h33, REC_W'(i * 13 + 1), 1'b1, 8'h33);
    flush();
  endtask

  task automatic t_miss_zero();
    req = "R6";
    for (int i = 0; i < 2 * D; i++)
      step(1'b1, 8'h45, REC_W'(9'h1FF), 1'b1, 8'h44);
    flush();
  endtask

  task automatic t_idle();
    req = "R7";
    for (int i = 0; i < 2 * D; i++)
      step(1'b1, 8'h55, REC_W'(i + 3), 1'b0, 8'h55);
    flush();
  endtask

  task automatic t_stream();
    logic [15:0] lf;
    lf  = 16'hACE1;
    req = "R2 R3 R4 stream";
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] | lf[5], {6'h1C, lf[2:1]}, REC_W'(lf[15:7]), 1'b1, {6'h1C, lf[9:8]});
    end
    flush();
  endtask

  task automatic t_reset_clear();
    req = "R1";
    for (int i = 0; i < D; i++) step(1'b1, 8'h66, REC_W'(i + 40), 1'b0, '0);
    do_reset();
    for (int i = 0; i < 2 * D; i++) step(1'b0, '0, '0, 1'b1, 8'h66);
    flush();
  endtask

  initial begin
    for (int i = 0; i < LOG_N; i++) begin
      lv_log[i] = 1'b0; ev_log[i] = 1'b0;
      lk_log[i] = '0; ek_log[i] = '0; er_log[i] = '0;
    end
    do_reset();
    req = "R1";
    flush();
    t_window();
    t_newest();
    t_no_push();
    t_miss_zero();
    t_idle();
    t_stream();
    t_reset_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule